// File: doc/BRIEF.md
# Descriptor Memory Access Arbiter

This block puts one single-ported synchronous RAM holding per-channel transfer descriptors behind two access ports so that it looks dual-ported to its users. The DMA engine port names a channel and a word within that channel's descriptor. The slave bus port, used by software, presents a flat word address with byte enables for writes. Each RAM word is 64 bits wide, and a descriptor spans four consecutive words. The engine can therefore fetch a whole descriptor in four back-to-back accesses.

The RAM can start only one access per cycle. The engine always has priority. When the engine requests, the slave bus is held off with its ready deasserted and keeps its request asserted. It is accepted in the first cycle in which the engine leaves the port idle. Read data comes back one cycle after the access is accepted on a shared data bus. A per-requester valid strobe tells each side whether the word is its own.

Top module: `desc_ram_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after an access is issued under reset, both read-valid outputs are low.
- R2: An engine read of channel c, word w reads RAM word address c*4+w (the channel number in the upper bits and the word select in the two lowest bits). The data appears on rd_data with rd_valid_eng high in the cycle after the request.
- R3: Whenever eng_req is high, slv_ready is low and no slave access is performed, whether the slave is idle or requesting.
- R4: slv_ready is high exactly when slv_req is high and eng_req is low. An accepted slave read returns its word with rd_valid_slv high in the following cycle.
- R5: A slave write updates only the bytes whose slv_be bit is set, where slv_be bit k covers data bits 8k+7 down to 8k. All other bytes of the word keep their previous value.
- R6: An engine write replaces all 64 bits of the addressed descriptor word.
- R7: A slave write that is stalled has no effect on the RAM. A slave request held through a stall is performed once, in the first cycle without an engine request.
- R8: At most one of rd_valid_eng and rd_valid_slv is high in any cycle. A write produces no read-valid in the next cycle.
- R9: Every channel's four descriptor words are distinct locations, and the slave address c*4+w reaches the same word the engine reaches with channel c and word w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_req | input | 1 | Engine access request, never stalled |
| eng_we | input | 1 | Engine access is a full-word write |
| eng_ch | input | CH_W | Channel whose descriptor is accessed |
| eng_word | input | WSEL_W | Word index inside the descriptor |
| eng_wdata | input | DATA_W | Engine write data |
| slv_req | input | 1 | Slave bus access request |
| slv_we | input | 1 | Slave access is a write |
| slv_addr | input | CH_W+WSEL_W | Slave word address |
| slv_be | input | DATA_W/8 | Slave byte enables for writes |
| slv_wdata | input | DATA_W | Slave write data |
| slv_ready | output | 1 | Slave access accepted this cycle |
| rd_valid_eng | output | 1 | rd_data carries the engine's read result |
| rd_valid_slv | output | 1 | rd_data carries the slave's read result |
| rd_data | output | DATA_W | Read data, one cycle after acceptance |

## Verification
The bench builds the block with CH_W set to 3, which gives eight channels and a 32-word RAM, and keeps the 64-bit word and four-word descriptors. With this size every word can be written through one port and read back through the other. Every channel-to-address mapping and the aliasing between the two address forms are therefore tested exhaustively. The narrow address space also lets a short vector table place stalled writes, byte-masked writes and the lowest and highest addresses next to one another.

// File: rtl/desc_arb_pkg.sv
// Package: shared types for the descriptor memory access arbiter.
// Assumes: a single RAM port, so at most one owner per cycle.
package desc_arb_pkg;

    // Which requester owns the RAM port in the current cycle.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_ENG  = 2'd1,
        OWN_SLV  = 2'd2
    } port_owner_e;

endpackage

// File: rtl/desc_addr_map.sv
// Module: desc_addr_map
// Converts an engine channel number and descriptor word index into a
// flat RAM word address. Assumes descriptors of 2**WSEL_W words packed
// back to back, channel 0 at address 0.
module desc_addr_map #(
    parameter int CH_W   = 4,
    parameter int WSEL_W = 2,
    localparam int ADDR_W = CH_W + WSEL_W
) (
    input  logic [CH_W-1:0]   ch,
    input  logic [WSEL_W-1:0] word,
    output logic [ADDR_W-1:0] addr
);

    // Base is the channel scaled by descriptor size; word selects within it.
    always_comb begin
        addr = {ch, word};
    end

endmodule

// File: rtl/desc_port_arb.sv
// Module: desc_port_arb
// Fixed-priority grant of the single RAM port: the engine always wins,
// the slave is granted only in a cycle the engine leaves idle.
// Assumes the slave keeps its request stable while not ready.
module desc_port_arb
    import desc_arb_pkg::*;
(
    input  logic        eng_req,
    input  logic        slv_req,
    output port_owner_e owner,
    output logic        slv_ready
);

    // Priority decode of the two requests.
    always_comb begin
        if (eng_req) begin
            owner = OWN_ENG;
        end else if (slv_req) begin
            owner = OWN_SLV;
        end else begin
            owner = OWN_NONE;
        end
        slv_ready = (owner == OWN_SLV);
    end

endmodule

// File: rtl/desc_port_mux.sv
// Module: desc_port_mux
// Steers the winning requester's command onto the RAM port and expands
// byte enables. Engine writes always enable every byte lane.
// Assumes DATA_W is a multiple of 8.
module desc_port_mux
    import desc_arb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64,
    localparam int BE_W  = DATA_W / 8
) (
    input  port_owner_e        owner,
    input  logic [ADDR_W-1:0]  eng_addr,
    input  logic               eng_we,
    input  logic [DATA_W-1:0]  eng_wdata,
    input  logic [ADDR_W-1:0]  slv_addr,
    input  logic               slv_we,
    input  logic [BE_W-1:0]    slv_be,
    input  logic [DATA_W-1:0]  slv_wdata,
    output logic               ram_en,
    output logic               ram_we,
    output logic [ADDR_W-1:0]  ram_addr,
    output logic [BE_W-1:0]    ram_be,
    output logic [DATA_W-1:0]  ram_wdata
);

    // Select the command of whichever side owns the port.
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = eng_addr;
        ram_be    = '0;
        ram_wdata = eng_wdata;
        unique case (owner)
            OWN_ENG: begin
                ram_en    = 1'b1;
                ram_we    = eng_we;
                ram_addr  = eng_addr;
                ram_be    = {BE_W{1'b1}};
                ram_wdata = eng_wdata;
            end
            OWN_SLV: begin
                ram_en    = 1'b1;
                ram_we    = slv_we;
                ram_addr  = slv_addr;
                ram_be    = slv_be;
                ram_wdata = slv_wdata;
            end
            default: begin
                ram_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/desc_sp_ram.sv
// Module: desc_sp_ram
// Behavioral single-port synchronous RAM with per-byte write enables and
// a registered read port. Contents are not reset.
// Assumes one access per cycle; a write returns no read data.
module desc_sp_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64,
    localparam int BE_W  = DATA_W / 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] bit_mask;

    // Widen each byte enable over its eight data bits.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign bit_mask[b*8 +: 8] = {8{be[b]}};
    end

    // Masked write or registered read of the addressed word.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= (mem[addr] & ~bit_mask) | (wdata & bit_mask);
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/desc_rsp_tag.sv
// Module: desc_rsp_tag
// Registers which requester issued the read accepted this cycle, so the
// RAM output of the next cycle is flagged for its owner.
// Assumes the RAM read latency is exactly one cycle.
module desc_rsp_tag
    import desc_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  port_owner_e owner,
    input  logic        ram_we,
    output logic        valid_eng,
    output logic        valid_slv
);

    // Tag the pending read result with its requester; clear on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_eng <= 1'b0;
            valid_slv <= 1'b0;
        end else begin
            valid_eng <= (owner == OWN_ENG) && !ram_we;
            valid_slv <= (owner == OWN_SLV) && !ram_we;
        end
    end

endmodule

// File: rtl/desc_ram_arbiter.sv
// Module: desc_ram_arbiter (top)
// Presents a single-port descriptor RAM as two ports: an engine port
// with absolute priority and a slave bus port that is back-pressured
// while the engine uses the RAM. Read data returns one cycle after
// acceptance with a per-requester valid.
// Assumes the slave holds its command stable while slv_ready is low.
module desc_ram_arbiter
    import desc_arb_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int WSEL_W = 2,
    parameter int DATA_W = 64,
    localparam int ADDR_W = CH_W + WSEL_W,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [CH_W-1:0]   eng_ch,
    input  logic [WSEL_W-1:0] eng_word,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              slv_req,
    input  logic              slv_we,
    input  logic [ADDR_W-1:0] slv_addr,
    input  logic [BE_W-1:0]   slv_be,
    input  logic [DATA_W-1:0] slv_wdata,
    output logic              slv_ready,
    output logic              rd_valid_eng,
    output logic              rd_valid_slv,
    output logic [DATA_W-1:0] rd_data
);

    port_owner_e       owner;
    logic [ADDR_W-1:0] eng_addr;
    logic              ram_en;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [BE_W-1:0]   ram_be;
    logic [DATA_W-1:0] ram_wdata;

    desc_addr_map #(.CH_W(CH_W), .WSEL_W(WSEL_W)) u_map (
        .ch   (eng_ch),
        .word (eng_word),
        .addr (eng_addr)
    );

    desc_port_arb u_arb (
        .eng_req   (eng_req),
        .slv_req   (slv_req),
        .owner     (owner),
        .slv_ready (slv_ready)
    );

    desc_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .owner     (owner),
        .eng_addr  (eng_addr),
        .eng_we    (eng_we),
        .eng_wdata (eng_wdata),
        .slv_addr  (slv_addr),
        .slv_we    (slv_we),
        .slv_be    (slv_be),
        .slv_wdata (slv_wdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_be    (ram_be),
        .ram_wdata (ram_wdata)
    );

    desc_sp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .be    (ram_be),
        .wdata (ram_wdata),
        .rdata (rd_data)
    );

    desc_rsp_tag u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner     (owner),
        .ram_we    (ram_we),
        .valid_eng (rd_valid_eng),
        .valid_slv (rd_valid_slv)
    );

endmodule

// File: rtl/desc_arb_checker.sv
// Module: desc_arb_checker
// Protocol properties of the arbiter's ports, bound into every instance.
module desc_arb_checker (
    input logic clk,
    input logic rst_n,
    input logic eng_req,
    input logic eng_we,
    input logic slv_req,
    input logic slv_we,
    input logic slv_ready,
    input logic rd_valid_eng,
    input logic rd_valid_slv
);

    // The engine request always blocks the slave.
    assert_eng_blocks_slv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !slv_ready);

    // Ready only answers a pending slave request.
    assert_ready_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ready |-> slv_req);

    // An idle engine port lets a waiting slave through.
    assert_idle_grants_slv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_req && !eng_req) |-> slv_ready);

    // Engine reads return one cycle later to the engine.
    assert_eng_read_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_we) |=> (rd_valid_eng && !rd_valid_slv));

    // Accepted slave reads return one cycle later to the slave.
    assert_slv_read_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_ready && !slv_we) |=> (rd_valid_slv && !rd_valid_eng));

    // Never both owners flagged.
    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid_eng, rd_valid_slv}));

    // Engine writes yield no read data.
    assert_write_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_we) |=> !(rd_valid_eng || rd_valid_slv));

endmodule

bind desc_ram_arbiter desc_arb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eng_req      (eng_req),
    .eng_we       (eng_we),
    .slv_req      (slv_req),
    .slv_we       (slv_we),
    .slv_ready    (slv_ready),
    .rd_valid_eng (rd_valid_eng),
    .rd_valid_slv (rd_valid_slv)
);

// File: tb/tb_desc_ram_arbiter.sv
// Bench: vector table walk, then directed reset and exhaustive mapping tests.
module tb_desc_ram_arbiter;

    localparam int CH_W   = 3;
    localparam int WSEL_W = 2;
    localparam int DATA_W = 64;
    localparam int ADDR_W = CH_W + WSEL_W;
    localparam int BE_W   = DATA_W / 8;
    localparam int NWORDS = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              eng_req = 1'b0;
    logic              eng_we = 1'b0;
    logic [CH_W-1:0]   eng_ch = '0;
    logic [WSEL_W-1:0] eng_word = '0;
    logic [DATA_W-1:0] eng_wdata = '0;
    logic              slv_req = 1'b0;
    logic              slv_we = 1'b0;
    logic [ADDR_W-1:0] slv_addr = '0;
    logic [BE_W-1:0]   slv_be = '0;
    logic [DATA_W-1:0] slv_wdata = '0;
    logic              slv_ready;
    logic              rd_valid_eng;
    logic              rd_valid_slv;
    logic [DATA_W-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    desc_ram_arbiter #(.CH_W(CH_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)) dut (.*);

    typedef struct packed {
        logic              e_req;
        logic              e_we;
        logic [CH_W-1:0]   e_ch;
        logic [WSEL_W-1:0] e_word;
        logic [DATA_W-1:0] e_wd;
        logic              s_req;
        logic              s_we;
        logic [ADDR_W-1:0] s_addr;
        logic [BE_W-1:0]   s_be;
        logic [DATA_W-1:0] s_wd;
        logic              x_rdy;
        logic              x_ve;
        logic              x_vs;
        logic [DATA_W-1:0] x_data;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        // R6: engine full write ch2 w1
        '{1'b1, 1'b1, 3'd2, 2'd1, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 5'd0, 8'h00, 64'h0,
          1'b0, 1'b0, 1'b0, 64'h0},
        // R9/R4: slave reads the same word at 2*4+1
        '{1'b0, 1'b0, 3'd0, 2'd0, 64'h0, 1'b1, 1'b0, 5'd9, 8'h00, 64'h0,
          1'b1, 1'b0, 1'b1, 64'h1111_2222_3333_4444},
        // R5: slave writes low four bytes
        '{1'b0, 1'b0, 3'd0, 2'd0, 64'h0, 1'b1, 1'b1, 5'd9, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD,
          1'b1, 1'b0, 1'b0, 64'h0},
        // R3/R2: engine read wins over a slave write
        '{1'b1, 1'b0, 3'd2, 2'd1, 64'h0, 1'b1, 1'b1, 5'd9, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF,
          1'b0, 1'b1, 1'b0, 64'h1111_2222_CCCC_DDDD},
        // R7: stalled write left no trace
        '{1'b0, 1'b0, 3'd0, 2'd0, 64'h0, 1'b1, 1'b0, 5'd9, 8'h00, 64'h0,
          1'b1, 1'b0, 1'b1, 64'h1111_2222_CCCC_DDDD},
        // R5: full slave write to the top word
        '{1'b0, 1'b0, 3'd0, 2'd0, 64'h0, 1'b1, 1'b1, 5'd31, 8'hFF, 64'h0123_4567_89AB_CDEF,
          1'b1, 1'b0, 1'b0, 64'h0},
        // R5: edge bytes only
        '{1'b0, 1'b0, 3'd0, 2'd0, 64'h0, 1'b1, 1'b1, 5'd31, 8'h81, 64'hEE00_0000_0000_0077,
          1'b1, 1'b0, 1'b0, 64'h0},
        // R2/R9: engine reads ch7 w3
        '{1'b1, 1'b0, 3'd7, 2'd3, 64'h0, 1'b0, 1'b0, 5'd0, 8'h00, 64'h0,
          1'b0, 1'b1, 1'b0, 64'hEE23_4567_89AB_CD77},
        // R3/R8: engine write ch0 w0 stalls a slave read, no valid
        '{1'b1, 1'b1, 3'd0, 2'd0, 64'h5555_6666_7777_8888, 1'b1, 1'b0, 5'd0, 8'h00, 64'h0,
          1'b0, 1'b0, 1'b0, 64'h0},
        // R7: held slave read goes through once engine is idle
        '{1'b0, 1'b0, 3'd0, 2'd0, 64'h0, 1'b1, 1'b0, 5'd0, 8'h00, 64'h0,
          1'b1, 1'b0, 1'b1, 64'h5555_6666_7777_8888},
        // R8: idle cycle
        '{1'b0, 1'b0, 3'd0, 2'd0, 64'h0, 1'b0, 1'b0, 5'd0, 8'h00, 64'h0,
          1'b0, 1'b0, 1'b0, 64'h0}
    };

    function automatic logic [DATA_W-1:0] pat(input int i, input int salt);
        return {32'hC0DE_0000 + 32'(i) + 32'(salt), ~(32'(i) * 32'h0101_0101)};
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        eng_req = 1'b0; eng_we = 1'b0; eng_ch = '0; eng_word = '0; eng_wdata = '0;
        slv_req = 1'b0; slv_we = 1'b0; slv_addr = '0; slv_be = '0; slv_wdata = '0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R1: access issued under reset returns nothing
        idle_inputs();
        @(negedge clk);
        eng_req = 1'b1;
        @(posedge clk); #1;
        check("R1 eng valid in reset", 64'(rd_valid_eng), 64'd0);
        check("R1 slv valid in reset", 64'(rd_valid_slv), 64'd0);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 valid after release", 64'({rd_valid_eng, rd_valid_slv}), 64'd0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            eng_req = VEC[v].e_req; eng_we = VEC[v].e_we; eng_ch = VEC[v].e_ch;
            eng_word = VEC[v].e_word; eng_wdata = VEC[v].e_wd;
            slv_req = VEC[v].s_req; slv_we = VEC[v].s_we; slv_addr = VEC[v].s_addr;
            slv_be = VEC[v].s_be; slv_wdata = VEC[v].s_wd;
            @(posedge clk); #1;
            check($sformatf("R3/R4 ready vec %0d", v), 64'(slv_ready), 64'(VEC[v].x_rdy));
            check($sformatf("R2/R8 eng valid vec %0d", v), 64'(rd_valid_eng), 64'(VEC[v].x_ve));
            check($sformatf("R4/R8 slv valid vec %0d", v), 64'(rd_valid_slv), 64'(VEC[v].x_vs));
            if (VEC[v].x_ve || VEC[v].x_vs)
                check($sformatf("R2/R5/R7 data vec %0d", v), rd_data, VEC[v].x_data);
        end

        // R9: slave fills every word, engine reads by channel and word
        for (int i = 0; i < NWORDS; i++) begin
            @(negedge clk);
            idle_inputs();
            slv_req = 1'b1; slv_we = 1'b1; slv_addr = ADDR_W'(i);
            slv_be = '1; slv_wdata = pat(i, 0);
        end
        for (int i = 0; i < NWORDS; i++) begin
            @(negedge clk);
            idle_inputs();
            eng_req = 1'b1; eng_ch = CH_W'(i >> WSEL_W); eng_word = WSEL_W'(i);
            @(posedge clk); #1;
            check($sformatf("R9 eng view of word %0d", i), rd_data, pat(i, 0));
        end

        // R6/R9: engine overwrites every word, slave reads back
        for (int i = 0; i < NWORDS; i++) begin
            @(negedge clk);
            idle_inputs();
            eng_req = 1'b1; eng_we = 1'b1; eng_ch = CH_W'(i >> WSEL_W);
            eng_word = WSEL_W'(i); eng_wdata = pat(i, 77);
        end
        for (int i = 0; i < NWORDS; i++) begin
            @(negedge clk);
            idle_inputs();
            slv_req = 1'b1; slv_addr = ADDR_W'(i);
            @(posedge clk); #1;
            check($sformatf("R6 slv view of word %0d", i), rd_data, pat(i, 77));
            check($sformatf("R4 slv valid word %0d", i), 64'(rd_valid_slv), 64'd1);
        end

        // R7: slave write held over three engine cycles lands once, after
        @(negedge clk);
        idle_inputs();
        eng_req = 1'b1; eng_ch = 3'd4;
        slv_req = 1'b1; slv_we = 1'b1; slv_addr = 5'd16; slv_be = 8'h0F;
        slv_wdata = 64'hDEAD_BEEF_DEAD_BEEF;
        repeat (3) begin
            @(posedge clk); #1;
            check("R3 ready low under engine", 64'(slv_ready), 64'd0);
            check("R7 engine sees old word", rd_data, pat(16, 77));
        end
        @(negedge clk);
        eng_req = 1'b0;
        @(posedge clk); #1;
        check("R7 held write accepted", 64'(slv_ready), 64'd1);
        @(negedge clk);
        idle_inputs();
        eng_req = 1'b1; eng_ch = 3'd4;
        @(posedge clk); #1;
        check("R5/R7 masked merge", rd_data, {pat(16, 77)[63:32], 32'hDEAD_BEEF});

        @(negedge clk);
        idle_inputs();
        @(posedge clk); #1;
        finish_run();
    end

endmodule